// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block is one watchdog timer slot of a bank of up to 64. Software programs a per-slot control word that holds a mode, a management-interrupt enable, a 16-bit reload length and the live down-counter. While the timer runs, the counter steps down once every `2^PRESCALE_LOG2` clock cycles (1024 by default). When it passes zero the timer expires. The counter then reloads from the length field, with `FILL_W` zero bits added below it, so every stage lasts the same time. The timer also moves to its next escalation stage. Software keeps the timer in its first stage by writing a poke register before each expiry.

The escalation is a state machine with five states. `ST_IDLE` means stopped. `ST_FIRST`, `ST_SECOND` and `ST_THIRD` are the three escalation stages, and `ST_TRIPPED` is the terminal state. A control write with a non-zero mode goes IDLE→FIRST, or restarts at FIRST from any running stage. A control write with mode 0 goes to IDLE. A poke goes from any running stage back to FIRST. The transitions on expiry are:

- FIRST: sets the pending bit, then goes to SECOND unless the mode is interrupt-only.
- SECOND: pulses the management interrupt if it is enabled, then goes to THIRD in full mode.
- THIRD: goes to TRIPPED.

TRIPPED holds until the block's reset input is applied.

The register port takes one request per cycle. A read answers one cycle later on `rsp_valid`/`rsp_rdata`.

Top module: `stage_wdog`

## Requirements
- R1: After reset all three outputs are low, the timer is stopped, and the control word, pending and enable registers read back zero.
- R2: The control word sits at byte offset 8·TIMER_IDX. Its fields are: mode in bits [1:0], management-interrupt enable in bit 2, length in bits [19:4], and live count in bits starting at bit 20 (CNT_W = 16+FILL_W bits wide). A write loads all fields and a read returns them. While the timer runs the count drops by one every 2^PRESCALE_LOG2 cycles.
- R3: A stage lasts (length·2^FILL_W + 1)·2^PRESCALE_LOG2 cycles, counted from a control write or poke. On each expiry the count reloads to length·2^FILL_W.
- R4: Mode 0 stops the timer at once: the count holds its value and no expiry occurs.
- R5: A write with data bit 0 set to offset 0x10000+8·TIMER_IDX is a poke. It reloads the count and returns a running timer to its first stage. The same write with bit 0 clear, or a write to another slot's poke offset, has no effect.
- R6: Every expiry in the first stage sets bit TIMER_IDX of the pending register at 0x200. Writing a 1 to that bit clears it, and writing 0 leaves it unchanged. In mode 1 every expiry is a first-stage expiry.
- R7: Writing a 1 to bit TIMER_IDX at 0x218 enables the core interrupt, and writing a 1 to that bit at 0x210 disables it. Zero bits and other timers' bits have no effect. Both addresses read back the enable mask.
- R8: `irq_core` is high exactly while the pending bit and the enable bit are both set. Disabling the interrupt keeps the pending bit.
- R9: In modes 2 and 3, with control bit 2 set, an expiry in the second stage makes `irq_mgmt` high for exactly one cycle, starting at the expiry edge. In mode 2 the timer stays in the second stage and pulses on each further expiry, and it never resets.
- R10: In mode 3 the third consecutive expiry without a poke raises `wdog_rst`. It stays high, ignoring pokes and control writes, until `rst_n` is applied.
- R11: With control bit 2 clear, the second stage still lasts its full time but `irq_mgmt` stays low.
- R12: A read gives `rsp_valid` high in the next cycle with the data. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 64 | Read data |
| irq_core | output | 1 | Core interrupt, level |
| irq_mgmt | output | 1 | Management-processor interrupt, one-cycle pulse |
| wdog_rst | output | 1 | Reset request, sticky |

## Verification
A wrong escalation state shows at the ports within at most one stage period. A stage skipped or repeated moves the `irq_mgmt` pulse or the `wdog_rst` edge by exactly one stage length. A poke that fails to return to the first stage shows up as a premature management pulse or reset. A count or prescaler error shifts the first rise of `irq_core` by a whole number of prescale periods. The bench checks the cycles on both sides of every expected edge, so an off-by-one appears at the first expiry. Stopped or frozen state is exposed through control-word readback, which returns the live count.

// File: rtl/stage_wdog_pkg.sv
package stage_wdog_pkg;

    localparam int unsigned REG_W      = 64;
    localparam int unsigned SLOT_BYTES = 8;
    localparam int unsigned PEND_OFS   = 'h200;
    localparam int unsigned ENCLR_OFS  = 'h210;
    localparam int unsigned ENSET_OFS  = 'h218;
    localparam int unsigned POKE_BASE  = 'h10000;
    localparam int unsigned LEN_LSB    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_THIRD,
        ST_TRIPPED
    } stage_e;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'd0,
        MODE_IRQ      = 2'd1,
        MODE_IRQ_MGMT = 2'd2,
        MODE_FULL     = 2'd3
    } mode_e;

endpackage

// File: rtl/stage_wdog_prescale.sv
module stage_wdog_prescale #(
    parameter int unsigned PRESCALE_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);

    generate
        if (PRESCALE_LOG2 == 0) begin : g_direct
            assign tick = run && !restart;
        end else begin : g_div
            logic [PRESCALE_LOG2-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (restart || !run) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick = run && !restart && (&div_q);
        end
    endgenerate

endmodule

// File: rtl/stage_wdog_count.sv
module stage_wdog_count #(
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned FILL_W = 8,
    localparam int unsigned CNT_W = LEN_W + FILL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart,
    input  logic [LEN_W-1:0] len,
    input  logic             tick,
    output logic             expire,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    assign reload = CNT_W'(len) << FILL_W;
    assign expire = tick && (cnt_q == '0);
    assign cnt    = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (restart || expire) begin
            cnt_q <= reload;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/stage_wdog_regs.sv
module stage_wdog_regs
    import stage_wdog_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned TIMER_IDX = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REG_W-1:0]  req_wdata,
    input  logic [REG_W-1:0]  ctrl_word,
    input  logic              pend_set,
    output logic              ctrl_wr,
    output logic              poke,
    output logic              pend,
    output logic              en,
    output logic              rsp_valid,
    output logic [REG_W-1:0]  rsp_rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(TIMER_IDX * SLOT_BYTES);
    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(PEND_OFS);
    localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(ENCLR_OFS);
    localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(ENSET_OFS);
    localparam logic [ADDR_W-1:0] A_POKE  = ADDR_W'(POKE_BASE + TIMER_IDX * SLOT_BYTES);

    logic             wr, rd, my_bit;
    logic             pend_q, en_q;
    logic             rsp_valid_q;
    logic [REG_W-1:0] rsp_q, rd_d;

    assign wr      = req_valid && req_write;
    assign rd      = req_valid && !req_write;
    assign my_bit  = req_wdata[TIMER_IDX];
    assign ctrl_wr = wr && (req_addr == A_CTRL);
    assign poke    = wr && (req_addr == A_POKE) && req_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (pend_set) begin
            pend_q <= 1'b1;
        end else if (wr && (req_addr == A_PEND) && my_bit) begin
            pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (wr && (req_addr == A_ENSET) && my_bit) begin
            en_q <= 1'b1;
        end else if (wr && (req_addr == A_ENCLR) && my_bit) begin
            en_q <= 1'b0;
        end
    end

    always_comb begin
        rd_d = '0;
        if (req_addr == A_CTRL) begin
            rd_d = ctrl_word;
        end else if (req_addr == A_PEND) begin
            rd_d[TIMER_IDX] = pend_q;
        end else if ((req_addr == A_ENCLR) || (req_addr == A_ENSET)) begin
            rd_d[TIMER_IDX] = en_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_q       <= '0;
        end else begin
            rsp_valid_q <= rd;
            if (rd) begin
                rsp_q <= rd_d;
            end
        end
    end

    assign pend      = pend_q;
    assign en        = en_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_q;

endmodule

// File: rtl/stage_wdog.sv
module stage_wdog
    import stage_wdog_pkg::*;
#(
    parameter int unsigned PRESCALE_LOG2 = 10,
    parameter int unsigned LEN_W         = 16,
    parameter int unsigned FILL_W        = 8,
    parameter int unsigned TIMER_IDX     = 63,
    parameter int unsigned ADDR_W        = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              irq_core,
    output logic              irq_mgmt,
    output logic              wdog_rst
);

    localparam int unsigned CNT_W   = LEN_W + FILL_W;
    localparam int unsigned CNT_LSB = LEN_LSB + LEN_W;

    stage_e           state_q, state_d, start_state;
    mode_e            mode_q;
    logic             mgmt_en_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_q;
    logic [REG_W-1:0] ctrl_word;
    logic             ctrl_wr, poke, ctrl_wr_eff, poke_eff, restart;
    logic             run, tick, expire;
    logic             pend, en, pend_set, mgmt_q;
    logic             unused_wdata;

    assign unused_wdata = ^req_wdata;

    assign ctrl_wr_eff = ctrl_wr && (state_q != ST_TRIPPED);
    assign poke_eff    = poke && (state_q != ST_TRIPPED);
    assign restart     = ctrl_wr_eff || poke_eff;
    assign run         = (state_q == ST_FIRST) || (state_q == ST_SECOND) ||
                         (state_q == ST_THIRD);
    assign start_state = (req_wdata[1:0] == MODE_OFF) ? ST_IDLE : ST_FIRST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_OFF;
            mgmt_en_q <= 1'b0;
            len_q     <= '0;
        end else if (ctrl_wr_eff) begin
            mode_q    <= mode_e'(req_wdata[1:0]);
            mgmt_en_q <= req_wdata[2];
            len_q     <= req_wdata[LEN_LSB +: LEN_W];
        end
    end

    always_comb begin
        ctrl_word                       = '0;
        ctrl_word[1:0]                  = mode_q;
        ctrl_word[2]                    = mgmt_en_q;
        ctrl_word[LEN_LSB +: LEN_W]     = len_q;
        ctrl_word[CNT_LSB +: CNT_W]     = cnt_q;
    end

    stage_wdog_prescale #(
        .PRESCALE_LOG2(PRESCALE_LOG2)
    ) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .restart(restart),
        .tick   (tick)
    );

    stage_wdog_count #(
        .LEN_W (LEN_W),
        .FILL_W(FILL_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctrl_wr_eff),
        .load_val(req_wdata[CNT_LSB +: CNT_W]),
        .restart (poke_eff),
        .len     (len_q),
        .tick    (tick),
        .expire  (expire),
        .cnt     (cnt_q)
    );

    stage_wdog_regs #(
        .ADDR_W   (ADDR_W),
        .TIMER_IDX(TIMER_IDX)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .ctrl_word(ctrl_word),
        .pend_set (pend_set),
        .ctrl_wr  (ctrl_wr),
        .poke     (poke),
        .pend     (pend),
        .en       (en),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr_eff) state_d = start_state;
            end
            ST_FIRST: begin
                if (ctrl_wr_eff)                         state_d = start_state;
                else if (poke_eff)                       state_d = ST_FIRST;
                else if (expire && mode_q != MODE_IRQ)   state_d = ST_SECOND;
            end
            ST_SECOND: begin
                if (ctrl_wr_eff)                         state_d = start_state;
                else if (poke_eff)                       state_d = ST_FIRST;
                else if (expire && mode_q == MODE_FULL)  state_d = ST_THIRD;
            end
            ST_THIRD: begin
                if (ctrl_wr_eff)                         state_d = start_state;
                else if (poke_eff)                       state_d = ST_FIRST;
                else if (expire)                         state_d = ST_TRIPPED;
            end
            ST_TRIPPED: state_d = ST_TRIPPED;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    assign pend_set = expire && (state_q == ST_FIRST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mgmt_q <= 1'b0;
        end else begin
            mgmt_q <= expire && (state_q == ST_SECOND) && mgmt_en_q;
        end
    end

    assign irq_core = pend && en;
    assign irq_mgmt = mgmt_q;
    assign wdog_rst = (state_q == ST_TRIPPED);

endmodule

// File: rtl/stage_wdog_check.sv
module stage_wdog_check
    import stage_wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_mgmt,
    input logic             wdog_rst,
    input stage_e           stage,
    input logic [CNT_W-1:0] cnt,
    input logic             restart,
    input logic             expire
);

    assert_rst_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> wdog_rst);

    assert_rst_after_third_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst) |-> ($past(stage) == ST_THIRD));

    assert_tripped_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_TRIPPED) |=> $stable(cnt));

    assert_mgmt_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mgmt |=> !irq_mgmt);

    assert_mgmt_from_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mgmt |-> ($past(stage) == ST_SECOND));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_IDLE && !restart) |=> $stable(cnt));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !expire) |=> (cnt == $past(cnt) || cnt == ($past(cnt) - 1'b1)));

endmodule

bind stage_wdog stage_wdog_check #(
    .CNT_W(LEN_W + FILL_W)
) u_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_mgmt(irq_mgmt),
    .wdog_rst(wdog_rst),
    .stage   (state_q),
    .cnt     (cnt_q),
    .restart (restart),
    .expire  (expire)
);

// File: tb/stage_wdog_test.sv
module stage_wdog_test;

    localparam int unsigned P_LOG2 = 2;
    localparam int unsigned FILLW  = 2;
    localparam int unsigned IDX    = 5;
    localparam int unsigned AW     = 17;
    localparam logic [AW-1:0] CTRL_A = 17'h00028;
    localparam logic [AW-1:0] POKE_A = 17'h10028;
    localparam logic [AW-1:0] PEND_A = 17'h00200;
    localparam logic [AW-1:0] CLR_A  = 17'h00210;
    localparam logic [AW-1:0] SET_A  = 17'h00218;
    localparam logic [63:0]   MYBIT  = 64'h20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic          irq_core, irq_mgmt, wdog_rst;

    int n_checks = 0;
    int n_err    = 0;
    int mg_cnt   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    stage_wdog #(
        .PRESCALE_LOG2(P_LOG2),
        .LEN_W        (16),
        .FILL_W       (FILLW),
        .TIMER_IDX    (IDX),
        .ADDR_W       (AW)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .irq_core (irq_core),
        .irq_mgmt (irq_mgmt),
        .wdog_rst (wdog_rst)
    );

    always @(negedge clk) if (irq_mgmt) mg_cnt++;

    function automatic logic [63:0] cw(input int mode, input int mg, input int len);
        return 64'(mode) | (64'(mg) << 2) | (64'(len) << 4) | (64'(len << FILLW) << 20);
    endfunction

    function automatic int period(input int len);
        return (1 << P_LOG2) * ((len << FILLW) + 1);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [63:0] d, output logic v);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = rsp_rdata; v = rsp_valid;
        req_valid = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_n(2);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [63:0] d;
        logic        v;
        int          m0;

        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 irq_core", irq_core, 0);
        chk("R1 irq_mgmt", irq_mgmt, 0);
        chk("R1 wdog_rst", wdog_rst, 0);
        rd(CTRL_A, d, v); chk("R1 ctrl", d, 0);
        chk("R12 rsp_valid", v, 1);
        rd(PEND_A, d, v); chk("R1 pend", d, 0);
        rd(SET_A, d, v);  chk("R1 enable", d, 0);
        wr(17'h00100, 64'hFFFF);
        rd(17'h00100, d, v); chk("R12 unmapped", d, 0);

        // R7 enable set/clear
        wr(SET_A, 64'h10);
        rd(CLR_A, d, v); chk("R7 other bit ignored", d, 0);
        wr(SET_A, MYBIT);
        rd(CLR_A, d, v); chk("R7 read at clear addr", d, MYBIT);
        rd(SET_A, d, v); chk("R7 read at set addr", d, MYBIT);
        wr(CLR_A, 64'h0);
        rd(SET_A, d, v); chk("R7 zero write ignored", d, MYBIT);

        // R3 R6 R8 stage timing sweep, mode 1
        for (int len = 1; len <= 3; len++) begin
            int t;
            t = period(len);
            wr(CTRL_A, cw(1, 0, len));
            wait_n(t - 1); chk("R3 before expiry", irq_core, 0);
            wait_n(1);     chk("R3 at expiry", irq_core, 1);
            rd(PEND_A, d, v); chk("R6 pending bit", d, MYBIT);
            wr(PEND_A, MYBIT);
            wait_n(t - 3); chk("R6 cleared", irq_core, 0);
            wait_n(1);     chk("R6 mode1 re-sets", irq_core, 1);
            wr(PEND_A, 64'h0); chk("R6 zero write keeps", irq_core, 1);
            wr(PEND_A, MYBIT); chk("R6 one write clears", irq_core, 0);
            wr(CTRL_A, 64'h0);
        end

        // R2 count readback, R4 stop
        wr(CTRL_A, cw(1, 0, 3));
        wait_n(10);
        rd(CTRL_A, d, v);
        chk("R2 live count", d, 64'd1 | (64'd3 << 4) | (64'd10 << 20));
        wr(CTRL_A, (64'd3 << 4) | (64'd7 << 20));
        wait_n(40);
        rd(CTRL_A, d, v);
        chk("R4 count held", d, (64'd3 << 4) | (64'd7 << 20));
        chk("R4 no expiry", irq_core, 0);

        // R5 pokes keep first stage; wrong pokes ignored
        wr(CTRL_A, cw(1, 0, 1));
        for (int i = 0; i < 4; i++) begin
            wait_n(14);
            wr(POKE_A, 64'h1);
            chk("R5 poke holds off", irq_core, 0);
        end
        wait_n(5);
        wr(17'h10000, 64'h1);
        wait_n(3);
        wr(POKE_A, 64'h2);
        wait_n(9);  chk("R5 ignored pokes before", irq_core, 0);
        wait_n(1);  chk("R5 ignored pokes at expiry", irq_core, 1);
        wr(CTRL_A, 64'h0);
        wr(PEND_A, MYBIT);

        // R8 enable mask
        wr(CTRL_A, cw(1, 0, 1));
        wait_n(20); chk("R8 set", irq_core, 1);
        wr(CLR_A, MYBIT); chk("R8 masked", irq_core, 0);
        rd(PEND_A, d, v); chk("R8 pending kept", d, MYBIT);
        wr(SET_A, MYBIT); chk("R8 unmasked", irq_core, 1);
        wr(CTRL_A, 64'h0);
        wr(PEND_A, MYBIT);

        // R9 mode 2 repeated pulses, no reset
        m0 = mg_cnt;
        wr(CTRL_A, cw(2, 1, 1));
        wait_n(105);
        chk("R9 mode2 pulse count", 64'(mg_cnt - m0), 4);
        chk("R9 mode2 no reset", wdog_rst, 0);
        wr(CTRL_A, 64'h0);
        wr(PEND_A, MYBIT);

        // R9 R10 full escalation
        m0 = mg_cnt;
        wr(CTRL_A, cw(3, 1, 1));
        wait_n(19); chk("R10 stage1 before", irq_core, 0);
        wait_n(1);  chk("R10 stage1 irq", irq_core, 1);
        wait_n(19); chk("R9 before pulse", irq_mgmt, 0);
        wait_n(1);  chk("R9 pulse", irq_mgmt, 1);
        wait_n(1);  chk("R9 pulse one cycle", irq_mgmt, 0);
        wait_n(18); chk("R10 before reset", wdog_rst, 0);
        wait_n(1);  chk("R10 reset", wdog_rst, 1);
        wr(POKE_A, 64'h1);
        wr(CTRL_A, 64'h0);
        wait_n(50); chk("R10 sticky", wdog_rst, 1);
        chk("R9 single pulse", 64'(mg_cnt - m0), 1);
        do_reset();
        chk("R1 reset clears trip", wdog_rst, 0);
        rd(CTRL_A, d, v); chk("R1 ctrl after reset", d, 0);

        // R11 management disabled
        wr(SET_A, MYBIT);
        m0 = mg_cnt;
        wr(CTRL_A, cw(3, 0, 1));
        wait_n(59); chk("R11 before reset", wdog_rst, 0);
        wait_n(1);  chk("R11 reset timing", wdog_rst, 1);
        chk("R11 no mgmt pulse", 64'(mg_cnt - m0), 0);
        do_reset();
        wr(SET_A, MYBIT);

        // R5 poke in second stage returns to first
        m0 = mg_cnt;
        wr(CTRL_A, cw(3, 1, 1));
        wait_n(20); chk("R5 first expiry", irq_core, 1);
        wr(PEND_A, MYBIT);
        wait_n(9);
        wr(POKE_A, 64'h1);
        wait_n(19); chk("R5 restarted before", irq_core, 0);
        wait_n(1);  chk("R5 restarted at first", irq_core, 1);
        chk("R5 no mgmt after poke", 64'(mg_cnt - m0), 0);
        wait_n(19); chk("R9 after poke before", irq_mgmt, 0);
        wait_n(1);  chk("R9 after poke pulse", irq_mgmt, 1);
        wait_n(19); chk("R10 after poke before", wdog_rst, 0);
        wait_n(1);  chk("R10 after poke reset", wdog_rst, 1);
        do_reset();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule